// File: doc/BRIEF.md
# Masked Interrupt Request Collector

This block gathers up to eight interrupt request lines into a pending register. It drives a single interrupt output toward a system-level interrupt controller. Hardware sources raise and lower requests through a set vector and a clear vector. Software reaches the block over a byte-wide register bus that completes in one cycle. Over that bus it writes an active-low mask, acknowledges one request at a time by number, and reads back the raw pending bits.

The output follows a registered "interrupting" flag. The flag is recomputed at every clock edge from the pending and enable values that the same edge loads. Two one-cycle notification strobes mark the moments the output is posted and withdrawn. A second, placeholder controller sits beside the first. It has a storage-only mask and a status location that reads zero, and its acknowledge location ignores writes. It exists so that software written for a paired arrangement keeps working.

Top module: `irq_collector`

## Requirements
- R1: After reset the pending register and the enable mask are all zero, and the interrupt output and both strobes are low.
- R2: Each clock, the bits of `set_vec_i` are ORed into pending and the bits of `clr_vec_i` are cleared. When the same bit is both set and cleared in one cycle, the set wins.
- R3: A narrow write to address 1 loads the enable mask with the bitwise inverse of the written byte, so a written 1 disables that line.
- R4: `irq_o` is high in the cycle after an edge at which (pending AND enable) becomes nonzero. It is low in the cycle after an edge at which that value becomes zero.
- R5: `irq_post_o` pulses for one cycle together with a rise of `irq_o`, and `irq_drop_o` pulses for one cycle together with a fall. The two strobes are never high at once.
- R6: A narrow write to address 2 clears the pending bit numbered by data bits [3:0]. Values 8 to 15 clear nothing, and data bits [7:4] are ignored.
- R7: When an acknowledge and a hardware set name the same bit in one cycle, the bit stays pending.
- R8: A read at address 0 returns the pending byte zero-extended to 64 bits. This holds for a narrow access (`bus_wide_i`=0) and for a wide one (`bus_wide_i`=1).
- R9: For the second controller, a read at address 4 returns zero. Writes at address 5 (mask storage) and address 6 (acknowledge) change neither pending nor `irq_o`.
- R10: Wide writes (`bus_wide_i`=1) are ignored. Reads at any address other than 0 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_vec_i | input | 8 | Hardware request set bits |
| clr_vec_i | input | 8 | Hardware request clear bits |
| bus_valid_i | input | 1 | Register access this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_wide_i | input | 1 | 1 = 64-bit access, 0 = byte access |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data byte |
| bus_rdata_o | output | 64 | Read data, valid in the access cycle |
| irq_o | output | 1 | Interrupt output (interrupting flag) |
| irq_post_o | output | 1 | One-cycle strobe when the output is posted |
| irq_drop_o | output | 1 | One-cycle strobe when the output is withdrawn |

## Verification
A software acknowledge and a hardware set or clear can land on the pending register in the same cycle. A mask write can likewise land together with a change in pending. The bench drives an acknowledge of bit 7 in the very cycle that `set_vec_i` raises bit 7, and it drives an overlapping set and clear vector. It then reads the status location on the following cycle and judges the result against the set-wins rule. The bench also checks that the output and its strobes reflect the merged result of both updates rather than either one alone.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;

   localparam int REG_ADDR_W = 3;

   localparam logic [REG_ADDR_W-1:0] A_STAT_P = 3'd0;
   localparam logic [REG_ADDR_W-1:0] A_MASK_P = 3'd1;
   localparam logic [REG_ADDR_W-1:0] A_ACK_P  = 3'd2;
   localparam logic [REG_ADDR_W-1:0] A_STAT_S = 3'd4;
   localparam logic [REG_ADDR_W-1:0] A_MASK_S = 3'd5;
   localparam logic [REG_ADDR_W-1:0] A_ACK_S  = 3'd6;

   localparam int ACK_SEL_W = 4;

   typedef struct packed {
      logic wr_mask_p;
      logic wr_ack_p;
      logic wr_mask_s;
      logic wr_ack_s;
      logic rd_stat_p;
      logic rd_stat_s;
   } strobe_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
   import irq_collector_pkg::*;
#(
   parameter int ADDR_W = REG_ADDR_W
) (
   input  logic              valid_i,
   input  logic              write_i,
   input  logic              wide_i,
   input  logic [ADDR_W-1:0] addr_i,
   output strobe_t           stb_o
);

   logic nwr;
   logic rd;
   logic [REG_ADDR_W-1:0] a;

   generate
      if (ADDR_W < REG_ADDR_W) begin : g_bad_addr
         $error("irq_bus_decode: ADDR_W too small");
      end
      if (ADDR_W > REG_ADDR_W) begin : g_hi_addr
         logic hi_zero;
         assign hi_zero = (addr_i[ADDR_W-1:REG_ADDR_W] == '0);
         assign a       = hi_zero ? addr_i[REG_ADDR_W-1:0] : 3'd7;
      end else begin : g_exact_addr
         assign a = addr_i;
      end
   endgenerate

   // narrow writes only; wide reads and narrow reads both allowed
   assign nwr = valid_i & write_i & ~wide_i;
   assign rd  = valid_i & ~write_i;

   always_comb begin
      stb_o           = '0;
      stb_o.wr_mask_p = nwr & (a == A_MASK_P);
      stb_o.wr_ack_p  = nwr & (a == A_ACK_P);
      stb_o.wr_mask_s = nwr & (a == A_MASK_S);
      stb_o.wr_ack_s  = nwr & (a == A_ACK_S);
      stb_o.rd_stat_p = rd  & (a == A_STAT_P);
      stb_o.rd_stat_s = rd  & (a == A_STAT_S);
   end

endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg
   import irq_collector_pkg::*;
#(
   parameter int NLINES = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] set_i,
   input  logic [NLINES-1:0] clr_i,
   input  logic              ack_i,
   input  logic [DATA_W-1:0] ack_data_i,
   output logic [NLINES-1:0] pend_q_o,
   output logic [NLINES-1:0] pend_d_o
);

   logic [NLINES-1:0]    ack_bits;
   logic [ACK_SEL_W-1:0] sel;
   logic [NLINES-1:0]    pend_q;

   assign sel = ack_data_i[ACK_SEL_W-1:0];

   // one-hot decode of the acknowledged line; selector values past the
   // last line decode to nothing
   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_ack
         assign ack_bits[i] = ack_i & (sel == ACK_SEL_W'(i));
      end
   endgenerate

   // set has the last word over clear and acknowledge
   assign pend_d_o = (pend_q & ~clr_i & ~ack_bits) | set_i;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d_o;
   end

   assign pend_q_o = pend_q;

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int    NLINES     = 8,
   parameter int    DATA_W     = 8,
   parameter bit    HAS_SECOND = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_p_i,
   input  logic              wr_s_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [NLINES-1:0] en_q_o,
   output logic [NLINES-1:0] en_d_o
);

   logic [NLINES-1:0] en_q;

   // active-low mask: the stored enable is the inverted byte
   assign en_d_o = wr_p_i ? ~wdata_i[NLINES-1:0] : en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d_o;
   end

   assign en_q_o = en_q;

   generate
      if (HAS_SECOND) begin : g_second
         // storage only: never reaches the interrupt path
         logic [DATA_W-1:0] mask_s_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      mask_s_q <= '0;
            else if (wr_s_i) mask_s_q <= wdata_i;
         end
      end else begin : g_no_second
         logic unused_s;
         assign unused_s = wr_s_i;
      end
   endgenerate

endmodule

// File: rtl/irq_out_tracker.sv
module irq_out_tracker #(
   parameter int NLINES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] pend_d_i,
   input  logic [NLINES-1:0] en_d_i,
   output logic              irq_o,
   output logic              post_o,
   output logic              drop_o
);

   logic flag_q;
   logic flag_d;
   logic post_q;
   logic drop_q;

   assign flag_d = |(pend_d_i & en_d_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         post_q <= 1'b0;
         drop_q <= 1'b0;
      end else begin
         // post only when not already posted, withdraw only when posted
         post_q <= ~flag_q &  flag_d;
         drop_q <=  flag_q & ~flag_d;
         flag_q <= flag_d;
      end
   end

   assign irq_o  = flag_q;
   assign post_o = post_q;
   assign drop_o = drop_q;

endmodule

// File: rtl/irq_collector.sv
module irq_collector
   import irq_collector_pkg::*;
#(
   parameter int NLINES     = 8,
   parameter int DATA_W     = 8,
   parameter int RDATA_W    = 64,
   parameter int ADDR_W     = 3,
   parameter bit HAS_SECOND = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NLINES-1:0]  set_vec_i,
   input  logic [NLINES-1:0]  clr_vec_i,
   input  logic               bus_valid_i,
   input  logic               bus_write_i,
   input  logic               bus_wide_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [RDATA_W-1:0] bus_rdata_o,
   output logic               irq_o,
   output logic               irq_post_o,
   output logic               irq_drop_o
);

   localparam int PAD_W = RDATA_W - NLINES;

   generate
      if (NLINES > DATA_W)           begin : g_chk_lines $error("NLINES exceeds DATA_W"); end
      if (NLINES > (1 << ACK_SEL_W)) begin : g_chk_sel   $error("NLINES exceeds acknowledge range"); end
      if (RDATA_W < NLINES)          begin : g_chk_rd    $error("RDATA_W too narrow"); end
   endgenerate

   strobe_t           stb;
   logic [NLINES-1:0] pend_q;
   logic [NLINES-1:0] pend_d;
   logic [NLINES-1:0] en_q;
   logic [NLINES-1:0] en_d;

   irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .valid_i (bus_valid_i),
      .write_i (bus_write_i),
      .wide_i  (bus_wide_i),
      .addr_i  (bus_addr_i),
      .stb_o   (stb)
   );

   irq_pending_reg #(.NLINES(NLINES), .DATA_W(DATA_W)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_vec_i),
      .clr_i      (clr_vec_i),
      .ack_i      (stb.wr_ack_p),
      .ack_data_i (bus_wdata_i),
      .pend_q_o   (pend_q),
      .pend_d_o   (pend_d)
   );

   irq_mask_bank #(.NLINES(NLINES), .DATA_W(DATA_W), .HAS_SECOND(HAS_SECOND)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_p_i  (stb.wr_mask_p),
      .wr_s_i  (stb.wr_mask_s),
      .wdata_i (bus_wdata_i),
      .en_q_o  (en_q),
      .en_d_o  (en_d)
   );

   irq_out_tracker #(.NLINES(NLINES)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_d_i (pend_d),
      .en_d_i   (en_d),
      .irq_o    (irq_o),
      .post_o   (irq_post_o),
      .drop_o   (irq_drop_o)
   );

   // second controller status and all other locations read as zero;
   // second acknowledge strobe is decoded but intentionally sinks here
   logic unused_rd;
   assign unused_rd = stb.rd_stat_s | stb.wr_ack_s;

   generate
      if (PAD_W > 0) begin : g_pad
         assign bus_rdata_o = stb.rd_stat_p ? {{PAD_W{1'b0}}, pend_q} : '0;
      end else begin : g_nopad
         assign bus_rdata_o = stb.rd_stat_p ? pend_q : '0;
      end
   endgenerate

endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
   parameter int NLINES  = 8,
   parameter int DATA_W  = 8,
   parameter int RDATA_W = 64,
   parameter int ADDR_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NLINES-1:0]  set_vec_i,
   input logic [NLINES-1:0]  clr_vec_i,
   input logic               bus_valid_i,
   input logic               bus_write_i,
   input logic               bus_wide_i,
   input logic [ADDR_W-1:0]  bus_addr_i,
   input logic [DATA_W-1:0]  bus_wdata_i,
   input logic [RDATA_W-1:0] bus_rdata_o,
   input logic               irq_o,
   input logic               irq_post_o,
   input logic               irq_drop_o,
   input logic [NLINES-1:0]  pend_q,
   input logic [NLINES-1:0]  en_q
);

   logic nwr;
   assign nwr = bus_valid_i & bus_write_i & ~bus_wide_i;

   assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec_i != '0) |=> ((pend_q & $past(set_vec_i)) == $past(set_vec_i)));

   assert_mask_inverts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (nwr && bus_addr_i == ADDR_W'(1)) |=> (en_q == ~$past(bus_wdata_i[NLINES-1:0])));

   assert_irq_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == |(pend_q & en_q));

   assert_strobes_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_post_o, irq_drop_o}));

   assert_post_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_post_o |-> irq_o);

   assert_drop_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_drop_o |-> !irq_o);

   assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (nwr && bus_addr_i == ADDR_W'(2) && bus_wdata_i[3] == 1'b0 && set_vec_i == '0)
      |=> !pend_q[$past(bus_wdata_i[2:0])]);

   assert_second_ack_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid_i && bus_addr_i == ADDR_W'(6) && set_vec_i == '0 && clr_vec_i == '0)
      |=> $stable(pend_q));

   always_comb begin
      if (rst_n && bus_valid_i && !bus_write_i && bus_addr_i == ADDR_W'(0))
         assert_status_read_R8: assert (bus_rdata_o == RDATA_W'(pend_q));
      if (rst_n && bus_valid_i && !bus_write_i && bus_addr_i != ADDR_W'(0))
         assert_other_read_zero_R10: assert (bus_rdata_o == '0);
   end

endmodule

bind irq_collector irq_collector_chk #(
   .NLINES(NLINES), .DATA_W(DATA_W), .RDATA_W(RDATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .set_vec_i(set_vec_i), .clr_vec_i(clr_vec_i),
   .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i), .bus_wide_i(bus_wide_i),
   .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
   .irq_o(irq_o), .irq_post_o(irq_post_o), .irq_drop_o(irq_drop_o),
   .pend_q(pend_q), .en_q(en_q)
);

// File: tb/irq_collector_test.sv
module irq_collector_test;

   localparam int CLK_PERIOD = 10;

   // op codes used by the table
   localparam logic [2:0] OP_NONE  = 3'd0;
   localparam logic [2:0] OP_MASKP = 3'd1;
   localparam logic [2:0] OP_ACKP  = 3'd2;
   localparam logic [2:0] OP_MASKS = 3'd3;
   localparam logic [2:0] OP_ACKS  = 3'd4;
   localparam logic [2:0] OP_WIDEM = 3'd5;

   typedef struct packed {
      logic [7:0] set;
      logic [7:0] clr;
      logic [2:0] op;
      logic [7:0] wd;
      logic [7:0] pend;
      logic       irq;
      logic       post;
      logic       drop;
   } row_t;

   localparam int NROWS = 16;
   localparam row_t TBL [NROWS] = '{
      '{8'h05, 8'h00, OP_NONE,  8'h00, 8'h05, 1'b0, 1'b0, 1'b0}, // R2 set, masked
      '{8'h00, 8'h00, OP_MASKP, 8'hFE, 8'h05, 1'b1, 1'b1, 1'b0}, // R3 R4 enable bit0
      '{8'h00, 8'h00, OP_NONE,  8'h00, 8'h05, 1'b1, 1'b0, 1'b0}, // R5 post one cycle
      '{8'h00, 8'h00, OP_ACKP,  8'h00, 8'h04, 1'b0, 1'b0, 1'b1}, // R6 ack bit0
      '{8'h00, 8'h00, OP_MASKP, 8'hFB, 8'h04, 1'b1, 1'b1, 1'b0}, // R3 enable bit2
      '{8'h00, 8'h00, OP_ACKP,  8'hF9, 8'h04, 1'b1, 1'b0, 1'b0}, // R6 sel 9 nothing
      '{8'h00, 8'h00, OP_ACKP,  8'h12, 8'h00, 1'b0, 1'b0, 1'b1}, // R6 upper ignored
      '{8'h80, 8'h80, OP_NONE,  8'h00, 8'h80, 1'b0, 1'b0, 1'b0}, // R2 set wins
      '{8'h00, 8'h00, OP_MASKS, 8'h00, 8'h80, 1'b0, 1'b0, 1'b0}, // R9 second mask
      '{8'h00, 8'h00, OP_WIDEM, 8'h7F, 8'h80, 1'b0, 1'b0, 1'b0}, // R10 wide write
      '{8'h00, 8'h00, OP_MASKP, 8'h7F, 8'h80, 1'b1, 1'b1, 1'b0}, // R3 enable bit7
      '{8'h00, 8'h00, OP_ACKS,  8'h07, 8'h80, 1'b1, 1'b0, 1'b0}, // R9 second ack
      '{8'h80, 8'h00, OP_ACKP,  8'h07, 8'h80, 1'b1, 1'b0, 1'b0}, // R7 ack vs set
      '{8'h00, 8'h80, OP_NONE,  8'h00, 8'h00, 1'b0, 1'b0, 1'b1}, // R2 R4 clear
      '{8'h03, 8'h01, OP_NONE,  8'h00, 8'h03, 1'b0, 1'b0, 1'b0}, // R2 overlap
      '{8'h00, 8'h01, OP_NONE,  8'h00, 8'h02, 1'b0, 1'b0, 1'b0}  // R2 clear only
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  set_vec, clr_vec;
   logic        bvalid, bwrite, bwide;
   logic [2:0]  baddr;
   logic [7:0]  bwdata;
   logic [63:0] brdata;
   logic        irq, post, drop;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_collector uut (
      .clk(clk), .rst_n(rst_n), .set_vec_i(set_vec), .clr_vec_i(clr_vec),
      .bus_valid_i(bvalid), .bus_write_i(bwrite), .bus_wide_i(bwide),
      .bus_addr_i(baddr), .bus_wdata_i(bwdata), .bus_rdata_o(brdata),
      .irq_o(irq), .irq_post_o(post), .irq_drop_o(drop)
   );

   task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      set_vec = '0; clr_vec = '0;
      bvalid = 1'b0; bwrite = 1'b0; bwide = 1'b0; baddr = '0; bwdata = '0;
   endtask

   task automatic drive_read(input logic [2:0] a, input logic w);
      idle();
      bvalid = 1'b1; baddr = a; bwide = w;
      #1;
   endtask

   task automatic drive_op(input logic [2:0] op, input logic [7:0] wd);
      bvalid = (op != OP_NONE);
      bwrite = 1'b1;
      bwide  = (op == OP_WIDEM);
      bwdata = wd;
      case (op)
         OP_MASKP, OP_WIDEM: baddr = 3'd1;
         OP_ACKP:            baddr = 3'd2;
         OP_MASKS:           baddr = 3'd5;
         OP_ACKS:            baddr = 3'd6;
         default:            baddr = 3'd0;
      endcase
   endtask

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      drive_read(3'd0, 1'b0);
      check64("R1 pending", brdata, 64'h0);
      check64("R1 irq/strobes", {61'b0, irq, post, drop}, 64'h0);

      for (int i = 0; i < NROWS; i++) begin
         set_vec = TBL[i].set;
         clr_vec = TBL[i].clr;
         drive_op(TBL[i].op, TBL[i].wd);
         @(posedge clk);
         @(negedge clk);
         drive_read(3'd0, 1'b0);
         check64($sformatf("R2/R6/R7/R8 row %0d pending", i), brdata, {56'b0, TBL[i].pend});
         check64($sformatf("R4 row %0d irq", i), {63'b0, irq}, {63'b0, TBL[i].irq});
         check64($sformatf("R5 row %0d strobes", i), {62'b0, post, drop},
                 {62'b0, TBL[i].post, TBL[i].drop});
      end

      // R8 wide read of status, pending is 0x02 here
      drive_read(3'd0, 1'b1);
      check64("R8 wide status", brdata, 64'h2);
      // R9 second status reads zero
      drive_read(3'd4, 1'b0);
      check64("R9 second status", brdata, 64'h0);
      // R10 other address reads zero
      drive_read(3'd1, 1'b0);
      check64("R10 mask address read", brdata, 64'h0);
      drive_read(3'd2, 1'b1);
      check64("R10 wide ack address read", brdata, 64'h0);

      // R1 reset mid-operation: enables return to zero
      @(negedge clk);
      idle();
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      set_vec = 8'h01;
      @(posedge clk);
      @(negedge clk);
      drive_read(3'd0, 1'b0);
      check64("R1 enables cleared by reset", {63'b0, irq}, 64'h0);
      check64("R1 pending after reset then set", brdata, 64'h1);

      // R3 R4 R5 enable all lines
      @(negedge clk);
      idle();
      drive_op(OP_MASKP, 8'h00);
      @(posedge clk);
      @(negedge clk);
      drive_read(3'd0, 1'b0);
      check64("R4 R5 enable all", {61'b0, irq, post, drop}, 64'b110);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule